// File: doc/BRIEF.md
# Decimating Long-Record Sample Capture

This block records a long run of ADC samples from one, two or all of its input channels into a local buffer. One buffer of `DEPTH` entries is split evenly among the active channels, so a single channel gets the whole depth, two channels get half each, and the all-channel setting gives each channel `DEPTH/NCH` entries. A decimation ratio from 1 to 4095 keeps only one of every N valid input samples, which stretches the recorded time window by N.

A capture starts on either a pretrigger pulse or a slow-control start pulse. The channel setting and ratio are sampled at that moment and held for the whole capture. `busy` stays high until the last entry is written, and then `done` goes high. After the capture, a simple address/data read port with one cycle of latency drains the buffer. Entry `a` holds the `a/G`-th kept sample of channel `a mod G`, where G is the number of active channels.

Top module: `ltc_top`

## Requirements
- R1: While reset is asserted, `busy` and `done` are 0 and `rd_data` is 0.
- R2: A one-cycle pulse on `start_pre` or on `start_sc` while `busy` is 0 sets `busy` and clears `done` from the next clock edge. It also samples `cfg_mode` and `cfg_ratio`.
- R3: A start pulse on either input while `busy` is 1 has no effect: the capture in progress continues and the buffer contents stay the same.
- R4: With ratio N, the first valid sample after a start is kept, and then every N-th valid sample after it. Cycles with `smp_vld` low do not count. A ratio of 0 behaves as 1.
- R5: `cfg_mode` 0 (one channel) records channel 0 only, in `DEPTH` entries: entry k holds the k-th kept sample.
- R6: `cfg_mode` 1 (two channels) records channels 0 and 1 interleaved, `DEPTH/2` samples each: entry 2k+c holds kept sample k of channel c.
- R7: `cfg_mode` 2 or 3 (all channels) records all `NCH` channels interleaved: entry `NCH`*k+c holds kept sample k of channel c.
- R8: `busy` falls and `done` rises at the clock edge that writes the final entry. `busy` and `done` are never both high.
- R9: `rd_data` shows the entry at `rd_addr` one cycle after `rd_en` is high. Addresses at or above `DEPTH` return 0. While `rd_en` is low, `rd_data` holds its value.
- R10: `done` clears on a read of address `DEPTH-1` or on an accepted start. Reads of other addresses leave it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_mode | input | 2 | Channel setting: 0 one, 1 two, 2/3 all |
| cfg_ratio | input | RW | Decimation ratio, 0 treated as 1 |
| start_pre | input | 1 | Pretrigger start pulse |
| start_sc | input | 1 | Slow-control start pulse |
| smp_vld | input | 1 | Input sample strobe, all channels together |
| smp_data | input | NCH*SW | Channel c in bits [c*SW +: SW] |
| rd_en | input | 1 | Read request |
| rd_addr | input | AW | Read address, AW = clog2(DEPTH+1) |
| rd_data | output | SW | Read data, one cycle after request |
| busy | output | 1 | Capture in progress |
| done | output | 1 | Capture complete, record not yet drained |

## Verification
A wrong write pointer or a wrong channel offset shows up as misplaced values during readout. It also moves the cycle in which `busy` falls, and the bench checks that cycle exactly. A decimation counter that drifts changes every kept sample after the first, so the first wrong entry points to the cycle where the error began. A restart accepted while busy resets the pointer and rewrites the early entries with later samples, which the full readout exposes. Errors in the flags show within one cycle of a start, of the final store, or of the read of the last address.

// File: rtl/ltc_pkg.sv
package ltc_pkg;

  typedef enum logic [1:0] {
    CH_ONE = 2'd0,
    CH_TWO = 2'd1,
    CH_ALL = 2'd2,
    CH_ALX = 2'd3
  } chmode_e;

  // active channel count for a channel setting
  function automatic int unsigned grp_of(input logic [1:0] m, input int unsigned nch);
    case (chmode_e'(m))
      CH_ONE:  return 1;
      CH_TWO:  return 2;
      default: return nch;
    endcase
  endfunction

endpackage

// File: rtl/ltc_dec_gate.sv
module ltc_dec_gate #(
  parameter int RW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [RW-1:0] ratio,
  output logic          take
);

  logic [RW-1:0] cnt_q, cnt_d, lim_m1;

  assign lim_m1 = (ratio == '0) ? '0 : ratio - RW'(1);
  assign take   = en && (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (en)
      cnt_d = (cnt_q >= lim_m1) ? '0 : cnt_q + RW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/ltc_ctrl.sv
module ltc_ctrl #(
  parameter int DEPTH = 96,
  parameter int NCH   = 4,
  parameter int RW    = 12,
  parameter int AW    = 7,
  parameter int GW    = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_req,
  input  logic [1:0]    mode_in,
  input  logic [RW-1:0] ratio_in,
  input  logic          take,
  input  logic          rd_last,
  output logic          go,
  output logic          we,
  output logic [AW-1:0] base,
  output logic [GW-1:0] grp,
  output logic [RW-1:0] ratio,
  output logic          busy,
  output logic          done
);

  logic          busy_q, busy_d, done_q, done_d;
  logic [1:0]    mode_q, mode_d;
  logic [RW-1:0] ratio_q, ratio_d;
  logic [AW-1:0] base_q, base_d;
  logic          last;

  assign go    = start_req && !busy_q;
  assign we    = busy_q && take;
  assign grp   = GW'(ltc_pkg::grp_of(mode_q, NCH));
  assign last  = (({1'b0, base_q} + (AW+1)'(grp)) == (AW+1)'(DEPTH));
  assign base  = base_q;
  assign ratio = ratio_q;
  assign busy  = busy_q;
  assign done  = done_q;

  always_comb begin
    busy_d  = busy_q;
    done_d  = done_q;
    mode_d  = mode_q;
    ratio_d = ratio_q;
    base_d  = base_q;
    if (go) begin
      busy_d  = 1'b1;
      done_d  = 1'b0;
      base_d  = '0;
      mode_d  = mode_in;
      ratio_d = ratio_in;
    end else begin
      if (we) begin
        if (last) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          base_d = base_q + AW'(grp);
        end
      end
      if (done_q && rd_last) done_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      mode_q  <= 2'd0;
      ratio_q <= '0;
      base_q  <= '0;
    end else begin
      busy_q  <= busy_d;
      done_q  <= done_d;
      mode_q  <= mode_d;
      ratio_q <= ratio_d;
      base_q  <= base_d;
    end
  end

endmodule

// File: rtl/ltc_mem.sv
module ltc_mem #(
  parameter int DEPTH = 96,
  parameter int NCH   = 4,
  parameter int SW    = 10,
  parameter int AW    = 7,
  parameter int GW    = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [AW-1:0]     base,
  input  logic [GW-1:0]     grp,
  input  logic [NCH*SW-1:0] wdata,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [SW-1:0]     rd_data
);

  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;

  logic [DEPTH-1:0][SW-1:0] cells;
  logic [SW-1:0]            rd_q, rd_d;

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    localparam logic [AW:0] IDX = (AW+1)'(i);
    logic [AW:0]   off;
    logic [CW-1:0] sel;
    logic          hit;
    logic [SW-1:0] cell_q;

    assign off = IDX - {1'b0, base};
    assign sel = CW'(IDX - {1'b0, base});
    assign hit = we && ({1'b0, base} <= IDX) && (off < (AW+1)'(grp));

    // storage cells carry no reset
    always_ff @(posedge clk) begin
      if (hit) cell_q <= wdata[SW*sel +: SW];
    end

    assign cells[i] = cell_q;
  end

  always_comb begin
    rd_d = rd_q;
    if (rd_en) begin
      rd_d = '0;
      if ({1'b0, rd_addr} < (AW+1)'(DEPTH)) rd_d = cells[rd_addr];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_q <= '0;
    else        rd_q <= rd_d;
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/ltc_top.sv
module ltc_top #(
  parameter int DEPTH = 96,
  parameter int NCH   = 4,
  parameter int SW    = 10,
  parameter int RW    = 12,
  localparam int AW   = $clog2(DEPTH + 1),
  localparam int GW   = $clog2(NCH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        cfg_mode,
  input  logic [RW-1:0]     cfg_ratio,
  input  logic              start_pre,
  input  logic              start_sc,
  input  logic              smp_vld,
  input  logic [NCH*SW-1:0] smp_data,
  input  logic              rd_en,
  input  logic [AW-1:0]     rd_addr,
  output logic [SW-1:0]     rd_data,
  output logic              busy,
  output logic              done
);

  logic [1:0]    sync_q;
  logic          rst_sync_n;
  logic          go, we, take, rd_last;
  logic [AW-1:0] base;
  logic [GW-1:0] grp;
  logic [RW-1:0] ratio;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end
  assign rst_sync_n = sync_q[1];

  assign rd_last = rd_en && ({1'b0, rd_addr} == (AW+1)'(DEPTH - 1));

  ltc_ctrl #(.DEPTH(DEPTH), .NCH(NCH), .RW(RW), .AW(AW), .GW(GW)) u_ctrl (
    .clk(clk), .rst_n(rst_sync_n),
    .start_req(start_pre || start_sc),
    .mode_in(cfg_mode), .ratio_in(cfg_ratio),
    .take(take), .rd_last(rd_last),
    .go(go), .we(we), .base(base), .grp(grp), .ratio(ratio),
    .busy(busy), .done(done)
  );

  ltc_dec_gate #(.RW(RW)) u_dec (
    .clk(clk), .rst_n(rst_sync_n),
    .clr(go), .en(busy && smp_vld), .ratio(ratio),
    .take(take)
  );

  ltc_mem #(.DEPTH(DEPTH), .NCH(NCH), .SW(SW), .AW(AW), .GW(GW)) u_mem (
    .clk(clk), .rst_n(rst_sync_n),
    .we(we), .base(base), .grp(grp), .wdata(smp_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data)
  );

endmodule

// File: rtl/ltc_chk.sv
module ltc_chk #(
  parameter int SW = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_pre,
  input logic          start_sc,
  input logic          rd_en,
  input logic [SW-1:0] rd_data,
  input logic          busy,
  input logic          done
);

  // R2: an accepted start raises busy
  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((start_pre || start_sc) && !busy) |=> busy);

  // R3: a start during a capture never interrupts it
  p_busy_keeps_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (busy || done));

  // R8: busy only ends together with done rising
  p_end_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $rose(done));

  // R8: flags are exclusive
  p_flag_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R9: read data holds without a request
  p_rd_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));

endmodule

bind ltc_top ltc_chk #(.SW(SW)) u_chk (
  .clk(clk), .rst_n(rst_sync_n),
  .start_pre(start_pre), .start_sc(start_sc),
  .rd_en(rd_en), .rd_data(rd_data),
  .busy(busy), .done(done)
);

// File: tb/tb_ltc_top.sv
module tb_ltc_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 96;
  localparam int NCH   = 4;
  localparam int SW    = 10;
  localparam int RW    = 12;
  localparam int AW    = $clog2(DEPTH + 1);

  typedef struct {
    int addr;
    int val;
    int req;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [1:0]        cfg_mode;
  logic [RW-1:0]     cfg_ratio;
  logic              start_pre, start_sc, smp_vld, rd_en;
  logic [NCH*SW-1:0] smp_data;
  logic [AW-1:0]     rd_addr;
  logic [SW-1:0]     rd_data;
  logic              busy, done;

  int    n_tests = 0;
  int    n_fail  = 0;
  item_t exp_q[$];
  logic  rd_q = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ltc_top #(.DEPTH(DEPTH), .NCH(NCH), .SW(SW), .RW(RW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_ratio(cfg_ratio),
    .start_pre(start_pre), .start_sc(start_sc), .smp_vld(smp_vld),
    .smp_data(smp_data), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .busy(busy), .done(done)
  );

  function automatic int sval(int t, int c, int seed);
    return (t * 13 + c * 101 + seed * 7) & 1023;
  endfunction

  function automatic int expv(int a, int g, int r, int seed);
    return sval((a / g) * r, a % g, seed);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard monitor: compare one cycle after each read request
  always @(posedge clk) rd_q <= rd_en;
  always @(negedge clk) begin
    if (rd_q) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R9 empty scoreboard", 0, 1);
      end else begin
        item_t it;
        it = exp_q.pop_front();
        chk(int'(rd_data) == it.val, $sformatf("R%0d addr %0d", it.req, it.addr),
            int'(rd_data), it.val);
      end
    end
  end

  task automatic start_run(input int m, input int ratio, input bit use_pre);
    cfg_mode  = 2'(m);
    cfg_ratio = RW'(ratio);
    if (use_pre) start_pre = 1'b1; else start_sc = 1'b1;
    @(negedge clk);
    start_pre = 1'b0;
    start_sc  = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    chk(done == 1'b0, "R10 done cleared by start", int'(done), 0);
  endtask

  // drives samples until the final kept one; R8 timing of busy/done
  task automatic feed(input int g, input int ratio, input int seed,
                      input bit gaps, input bit poke);
    int r;
    int last_t;
    int t;
    int cyc;
    r      = (ratio == 0) ? 1 : ratio;
    last_t = (DEPTH / g - 1) * r;
    t      = 0;
    cyc    = 0;
    while (t <= last_t) begin
      smp_vld = !gaps || (cyc % 2 == 0);
      for (int c = 0; c < NCH; c++) smp_data[c*SW +: SW] = SW'(sval(t, c, seed));
      if (poke && t == 10 && smp_vld) start_sc = 1'b1; // R3: ignored restart
      if (poke && t == 20 && smp_vld) start_pre = 1'b1; // R3: ignored restart
      if (smp_vld && t == last_t)
        chk(busy == 1'b1, "R8 busy before final store", int'(busy), 1);
      @(negedge clk);
      start_sc  = 1'b0;
      start_pre = 1'b0;
      if (smp_vld) t++;
      cyc++;
    end
    smp_vld = 1'b0;
    chk(busy == 1'b0, "R8 busy low after final store", int'(busy), 0);
    chk(done == 1'b1, "R8 done high after final store", int'(done), 1);
  endtask

  task automatic readout(input int g, input int ratio, input int seed,
                         input int req, input int n);
    int r;
    r = (ratio == 0) ? 1 : ratio;
    for (int a = 0; a < n; a++) begin
      item_t it;
      rd_en   = 1'b1;
      rd_addr = AW'(a);
      it.addr = a;
      it.val  = expv(a, g, r, seed);
      it.req  = req;
      exp_q.push_back(it);
      @(negedge clk);
    end
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    logic [SW-1:0] held;
    rst_n = 1'b0; cfg_mode = 2'd0; cfg_ratio = '0;
    start_pre = 1'b0; start_sc = 1'b0; smp_vld = 1'b0;
    smp_data = '0; rd_en = 1'b0; rd_addr = '0;
    repeat (5) @(negedge clk);
    // R1: reset state
    chk(busy == 1'b0, "R1 busy in reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done in reset", int'(done), 0);
    chk(rd_data == '0, "R1 rd_data in reset", int'(rd_data), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // run A: one channel (R5), ratio 1 (R4), pretrigger start, ignored restarts (R3)
    start_run(0, 1, 1'b1);
    feed(1, 1, 3, 1'b0, 1'b1);
    readout(1, 1, 3, 5, DEPTH - 1);
    chk(done == 1'b1, "R10 done kept before last address", int'(done), 1);
    readout(1, 1, 3, 3, DEPTH); // R3: contents match an uninterrupted capture
    chk(done == 1'b0, "R10 done cleared by last read", int'(done), 0);

    // R9: out-of-range read, then hold without request
    begin
      item_t it;
      rd_en = 1'b1; rd_addr = AW'(DEPTH);
      it.addr = DEPTH; it.val = 0; it.req = 9;
      exp_q.push_back(it);
      @(negedge clk);
      rd_en = 1'b0;
      @(negedge clk);
    end
    readout(1, 1, 3, 9, 5);
    held = rd_data;
    rd_addr = AW'(40);
    repeat (2) @(negedge clk);
    chk(rd_data == held, "R9 hold without read", int'(rd_data), int'(held));

    // run B: two channels (R6), ratio 3 with input gaps (R4), slow-control start
    start_run(1, 3, 1'b0);
    cfg_mode = 2'd0; cfg_ratio = RW'(9); // R2: changes after start are not used
    feed(2, 3, 11, 1'b1, 1'b0);
    readout(2, 3, 11, 6, DEPTH);

    // run C: all channels (R7), ratio 0 behaves as 1 (R4)
    start_run(2, 0, 1'b1);
    feed(NCH, 0, 5, 1'b0, 1'b0);
    readout(NCH, 0, 5, 4, DEPTH - 1);
    chk(done == 1'b1, "R10 done kept after partial read", int'(done), 1);

    // run D: setting 3 is also all channels (R7); start while done clears it (R10)
    start_run(3, 7, 1'b0);
    feed(NCH, 7, 21, 1'b1, 1'b1);
    readout(NCH, 7, 21, 7, DEPTH);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9 scoreboard drained", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule